// File: doc/BRIEF.md
# Four-Voice Chiptune Sample Generator

This block produces one 8-bit audio sample each time its sample strobe is asserted. It holds four voices. Voices 0 to 2 are tone voices, each with a 16-bit phase accumulator: a 25%-duty pulse, a square and a triangle. Voice 3 is a noise voice whose 16-bit frequency word serves as the state of a shift-register noise generator. Each voice scales its waveform by its own 8-bit volume.

On every strobe the block advances all accumulators and the noise state. It shapes each voice from the top bits of its updated phase. It then adds the four signed contributions and an 8-bit direct sample byte, wrapping modulo 256, and stores the result in an output register that can drive a PWM stage.

A host writes the volumes, frequency words, direct sample byte and tick period through a simple write port. A reloadable down-counter, stepped once per sample, emits a one-cycle tick for an external sequencer.

Top module: `chip4_synth`

## Requirements
- R1: Write map: address n (n = 0..3) sets the volume of voice n from `wr_data_i[7:0]`. Address 4+n sets the 16-bit frequency word of voice n. Address 8 sets the direct sample byte from `wr_data_i[7:0]`. Address 9 sets the tick period. Writes to addresses 10..15 change nothing. A volume, frequency, direct byte or period write has no effect on `sample_o` until the next strobe. A write made in the same cycle as a strobe is first used at the strobe after that one.
- R2: On each strobe, the phase of voices 0..2 becomes phase + frequency modulo 2^16. Without a strobe, the phase holds.
- R3: The pulse voice contributes -volume (mod 256) when bits 15 and 14 of its updated phase are both 1, and +volume otherwise. This gives a 25% duty cycle.
- R4: The square voice contributes -volume when bit 15 of its updated phase is 1, and +volume otherwise.
- R5: The triangle voice forms its contribution in these steps:
  - take the updated phase's high byte h;
  - if h[7] is set, replace h with ~h;
  - shift h left by one, keeping 8 bits;
  - subtract 128;
  - multiply the result, as signed 8-bit, by the volume taken as signed 8-bit.
  Its contribution is bits 14..7 of the 16-bit product.
- R6: On each strobe, the noise state shifts left by one. Its new bit 0 is the XOR of the new bit 15 and the new bit 14. A write to address 7 replaces the state. When that write coincides with a strobe, the written value becomes the state and no shift happens on that strobe.
- R7: The noise voice contributes -volume when bit 15 of its state after the strobe is 1, and +volume otherwise.
- R8: On the clock edge of a strobe, `sample_o` takes the modulo-256 sum of the four contributions and the direct byte. It is visible from the next cycle and holds between strobes.
- R9: A 16-bit counter decrements on every strobe. On the strobe where it would reach zero, it reloads from the period register, and `tick_o` is high for exactly the following cycle. `tick_o` is never high otherwise.
- R10: After reset, all phases, volumes, frequency words and the direct byte are 0. The noise state is the nonzero `LFSR_SEED` (default 16'hACE1). The period register and the counter hold `TICK_RST` (default 8). `sample_o` and `tick_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe, one per output sample |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| sample_o | output | 8 | Mixed sample, updated per strobe |
| tick_o | output | 1 | Sequencer tick pulse |

## Verification
The bench drives each tone voice alone at a frequency that divides the phase circle evenly. It counts negative samples to catch a pulse decoded on the wrong bits or a square with a swapped sign. It probes the triangle at its peak and trough, and with a negative volume, to expose a fold on the wrong bit or an unsigned multiply. It walks the noise state through a behavioural model, and writes the state in the same cycle as a strobe, so that a wrong tap or a lost write shows up as a diverging sample stream. It also sets periods of 1 and 3 to catch an off-by-one reload, and leaves gaps between strobes and makes writes to unused addresses to expose outputs that move without a strobe.

// File: rtl/chip4_pkg.sv
package chip4_pkg;
  localparam int unsigned NUM_VOICES  = 4;
  localparam int unsigned TONE_VOICES = 3;
  localparam int unsigned PHASE_W     = 16;
  localparam int unsigned VOL_W       = 8;
  localparam int unsigned SMP_W       = 8;
  localparam int unsigned TICK_W      = 16;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned DATA_W      = 16;

  localparam int unsigned ADDR_VOL_BASE  = 0;
  localparam int unsigned ADDR_FREQ_BASE = ADDR_VOL_BASE + NUM_VOICES;
  localparam int unsigned ADDR_PCM       = ADDR_FREQ_BASE + NUM_VOICES;
  localparam int unsigned ADDR_PERIOD    = ADDR_PCM + 1;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [VOL_W-1:0]   vol_t;
  typedef logic [SMP_W-1:0]   smp_t;
  typedef logic [TICK_W-1:0]  tick_t;

  typedef enum logic [1:0] {
    WAVE_PULSE,
    WAVE_SQUARE,
    WAVE_TRIANGLE
  } wave_e;

  function automatic wave_e wave_of(int unsigned idx);
    case (idx)
      0:       return WAVE_PULSE;
      1:       return WAVE_SQUARE;
      default: return WAVE_TRIANGLE;
    endcase
  endfunction
endpackage

// File: rtl/chip4_regs.sv
module chip4_regs
  import chip4_pkg::*;
#(
  parameter tick_t TICK_RST = 16'd8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output vol_t              vol_o   [NUM_VOICES],
  output phase_t            freq_o  [TONE_VOICES],
  output smp_t              pcm_o,
  output tick_t             period_o,
  output logic              noise_ld_o,
  output phase_t            noise_val_o
);
  vol_t   vol_q  [NUM_VOICES];
  phase_t freq_q [TONE_VOICES];
  smp_t   pcm_q;
  tick_t  period_q;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_vol
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_VOL_BASE + v));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  vol_q[v] <= '0;
      else if (hit) vol_q[v] <= wr_data_i[VOL_W-1:0];
    end
    assign vol_o[v] = vol_q[v];
  end

  for (genvar v = 0; v < TONE_VOICES; v++) begin : g_freq
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_FREQ_BASE + v));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  freq_q[v] <= '0;
      else if (hit) freq_q[v] <= wr_data_i[PHASE_W-1:0];
    end
    assign freq_o[v] = freq_q[v];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm_q    <= '0;
      period_q <= TICK_RST;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_PCM))    pcm_q    <= wr_data_i[SMP_W-1:0];
      if (wr_addr_i == ADDR_W'(ADDR_PERIOD)) period_q <= wr_data_i[TICK_W-1:0];
    end
  end

  assign pcm_o       = pcm_q;
  assign period_o    = period_q;
  // noise frequency word is the generator state, stored in the voice itself
  assign noise_ld_o  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_FREQ_BASE + TONE_VOICES));
  assign noise_val_o = wr_data_i[PHASE_W-1:0];
endmodule

// File: rtl/chip4_tone_voice.sv
module chip4_tone_voice
  import chip4_pkg::*;
#(
  parameter wave_e WAVE = WAVE_SQUARE
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  input  phase_t freq_i,
  input  vol_t   vol_i,
  output phase_t phase_o,
  output smp_t   contrib_o
);
  localparam int unsigned HB_LSB = PHASE_W - SMP_W;

  phase_t phase_q, phase_nxt;
  smp_t   hb, vol_neg;

  assign phase_nxt = phase_q + freq_i;
  assign hb        = phase_nxt[PHASE_W-1:HB_LSB];
  assign vol_neg   = SMP_W'(0) - vol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (step_i) phase_q <= phase_nxt;
  end

  if (WAVE == WAVE_PULSE) begin : g_pulse
    logic unused_low;
    assign unused_low = ^hb[SMP_W-3:0];
    assign contrib_o  = (hb[SMP_W-1] & hb[SMP_W-2]) ? vol_neg : vol_i;
  end else if (WAVE == WAVE_SQUARE) begin : g_square
    logic unused_low;
    assign unused_low = ^hb[SMP_W-2:0];
    assign contrib_o  = hb[SMP_W-1] ? vol_neg : vol_i;
  end else begin : g_triangle
    smp_t fold, dbl, ofs;
    logic signed [2*SMP_W-1:0] ofs_x, vol_x, prod;
    logic unused_prod;
    assign fold  = hb[SMP_W-1] ? ~hb : hb;
    assign dbl   = {fold[SMP_W-2:0], 1'b0};
    assign ofs   = dbl - SMP_W'(1 << (SMP_W - 1));
    assign ofs_x = (2*SMP_W)'($signed(ofs));
    assign vol_x = (2*SMP_W)'($signed(vol_i));
    assign prod  = ofs_x * vol_x;
    // upper product byte doubled: bits [2W-2 : W-1]
    assign contrib_o   = prod[2*SMP_W-2:SMP_W-1];
    assign unused_prod = ^{prod[2*SMP_W-1], prod[SMP_W-2:0], fold[SMP_W-1], dbl[0]};
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/chip4_noise_voice.sv
module chip4_noise_voice
  import chip4_pkg::*;
#(
  parameter phase_t SEED = 16'hACE1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  input  logic   load_i,
  input  phase_t load_val_i,
  input  vol_t   vol_i,
  output phase_t state_o,
  output smp_t   contrib_o
);
  phase_t state_q, shifted, state_nxt;

  // new bit0 = new bit15 ^ new bit14 = old bit14 ^ old bit13
  assign shifted = {state_q[PHASE_W-2:0], state_q[PHASE_W-2] ^ state_q[PHASE_W-3]};

  always_comb begin
    if (load_i)      state_nxt = load_val_i;
    else if (step_i) state_nxt = shifted;
    else             state_nxt = state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_nxt;
  end

  assign contrib_o = state_nxt[PHASE_W-1] ? (SMP_W'(0) - vol_i) : vol_i;
  assign state_o   = state_q;
endmodule

// File: rtl/chip4_tick_div.sv
module chip4_tick_div
  import chip4_pkg::*;
#(
  parameter tick_t TICK_RST = 16'd8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  tick_t period_i,
  output logic  tick_o
);
  tick_t cnt_q;
  logic  tick_q;
  logic  expire;

  assign expire = (cnt_q == TICK_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= TICK_RST;
      tick_q <= 1'b0;
    end else begin
      tick_q <= step_i && expire;
      if (step_i) cnt_q <= expire ? period_i : cnt_q - TICK_W'(1);
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/chip4_synth.sv
module chip4_synth
  import chip4_pkg::*;
#(
  parameter phase_t LFSR_SEED = 16'hACE1,
  parameter tick_t  TICK_RST  = 16'd8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sample_i,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  output logic [7:0]  sample_o,
  output logic        tick_o
);
  vol_t   vol_w     [NUM_VOICES];
  phase_t freq_w    [TONE_VOICES];
  phase_t phase_w   [TONE_VOICES];
  smp_t   contrib_w [NUM_VOICES];
  smp_t   pcm_w;
  tick_t  period_w;
  logic   noise_ld_w;
  phase_t noise_val_w;
  phase_t noise_state_w;
  smp_t   mix_sum;
  smp_t   sample_q;

  chip4_regs #(.TICK_RST(TICK_RST)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .vol_o       (vol_w),
    .freq_o      (freq_w),
    .pcm_o       (pcm_w),
    .period_o    (period_w),
    .noise_ld_o  (noise_ld_w),
    .noise_val_o (noise_val_w)
  );

  for (genvar v = 0; v < TONE_VOICES; v++) begin : g_tone
    chip4_tone_voice #(.WAVE(wave_of(v))) u_voice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (sample_i),
      .freq_i    (freq_w[v]),
      .vol_i     (vol_w[v]),
      .phase_o   (phase_w[v]),
      .contrib_o (contrib_w[v])
    );
  end

  chip4_noise_voice #(.SEED(LFSR_SEED)) u_noise (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (sample_i),
    .load_i     (noise_ld_w),
    .load_val_i (noise_val_w),
    .vol_i      (vol_w[TONE_VOICES]),
    .state_o    (noise_state_w),
    .contrib_o  (contrib_w[TONE_VOICES])
  );

  chip4_tick_div #(.TICK_RST(TICK_RST)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (sample_i),
    .period_i (period_w),
    .tick_o   (tick_o)
  );

  always_comb begin
    mix_sum = pcm_w;
    for (int v = 0; v < NUM_VOICES; v++) mix_sum = mix_sum + contrib_w[v];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sample_q <= '0;
    else if (sample_i) sample_q <= mix_sum;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/chip4_synth_chk.sv
module chip4_synth_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sample_i,
  input logic        wr_en_i,
  input logic [7:0]  sample_o,
  input logic        tick_o,
  input logic [15:0] phase0_i,
  input logic [15:0] noise_i
);
  a_r2_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(phase0_i));

  a_r8_sample_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(sample_o));

  a_r9_tick_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(sample_i));

  // R6: shifting never reaches the all-zero state from a live state
  a_r6_no_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (noise_i != 16'h0000 && noise_i != 16'h8000 && !wr_en_i)
    |=> (noise_i != 16'h0000 && noise_i != 16'h8000));
endmodule

bind chip4_synth chip4_synth_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sample_i (sample_i),
  .wr_en_i  (wr_en_i),
  .sample_o (sample_o),
  .tick_o   (tick_o),
  .phase0_i (phase_w[0]),
  .noise_i  (noise_state_w)
);

// File: tb/chip4_synth_tb.sv
`timescale 1ns/1ps
module chip4_synth_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [7:0]  sample_o;
  logic        tick_o;

  always #2 clk_i = ~clk_i;

  chip4_synth u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .sample_o(sample_o), .tick_o(tick_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string req = "R10";

  int m_ph[3], m_fr[3], m_vol[4];
  int m_lfsr, m_pcm, m_per, m_cnt, m_smp, m_tick;

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic int sx8(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int signed_vol(bit neg, int vol);
    return neg ? (256 - vol) & 255 : vol;
  endfunction

  function automatic int tone_val(int kind, int ph, int vol);
    int hb = ph / 256;
    int f;
    case (kind)
      0: return signed_vol(hb >= 192, vol);
      1: return signed_vol(hb >= 128, vol);
      default: begin
        f = (hb >= 128) ? 255 - hb : hb;
        f = (f * 2) % 256;
        return ((((f - 128) * sx8(vol)) >> 7) & 255);
      end
    endcase
  endfunction

  task automatic cyc(bit smp, bit we, int a, int d);
    int s;
    int n;
    sample_i  = smp;
    wr_en_i   = we;
    wr_addr_i = 4'(a);
    wr_data_i = 16'(d);
    m_tick = 0;
    if (smp) begin
      s = m_pcm;
      for (int i = 0; i < 3; i++) begin
        m_ph[i] = (m_ph[i] + m_fr[i]) % 65536;
        s += tone_val(i, m_ph[i], m_vol[i]);
      end
      if (we && a == 7) m_lfsr = d;
      else begin
        n = (m_lfsr * 2) % 65536;
        if (n >= 32768) n = n ^ 1;
        if ((n / 16384) % 2 == 1) n = n ^ 1;
        m_lfsr = n;
      end
      s += signed_vol(m_lfsr >= 32768, m_vol[3]);
      m_smp = s % 256;
      if (m_cnt == 1) begin m_cnt = m_per; m_tick = 1; end
      else m_cnt = (m_cnt + 65535) % 65536;
    end
    if (we) begin
      if (a < 4) m_vol[a] = d % 256;
      else if (a < 7) m_fr[a-4] = d;
      else if (a == 7) begin if (!smp) m_lfsr = d; end
      else if (a == 8) m_pcm = d % 256;
      else if (a == 9) m_per = d;
    end
    @(posedge clk_i);
    #1;
    chk(req, "sample_o", int'(sample_o), m_smp);
    chk(req, "tick_o", int'(tick_o), m_tick);
    sample_i = 1'b0;
    wr_en_i  = 1'b0;
  endtask

  task automatic wr(int a, int d);
    cyc(0, 1, a, d);
  endtask

  task automatic strobes(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0);
      if (gaps) cyc(0, 0, 0, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int neg;
    int prev;
    for (int i = 0; i < 3; i++) begin m_ph[i] = 0; m_fr[i] = 0; end
    for (int i = 0; i < 4; i++) m_vol[i] = 0;
    m_lfsr = 16'hACE1; m_pcm = 0; m_per = 8; m_cnt = 8; m_smp = 0; m_tick = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10", "reset sample_o", int'(sample_o), 0);
    chk("R10", "reset tick_o", int'(tick_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R10: seed-driven noise at zero volume, tick after 8 strobes
    req = "R10";
    strobes(10, 1);

    // R3: pulse alone, 16 strobes per period
    req = "R3";
    wr(0, 16'h0020); wr(4, 16'h1000);
    neg = 0;
    for (int k = 0; k < 16; k++) begin
      cyc(1, 0, 0, 0);
      if (sample_o == 8'hE0) neg++;
    end
    chk("R3", "pulse negative count", neg, 4);

    // R4: square alone
    req = "R4";
    wr(0, 0); wr(1, 16'h0011); wr(5, 16'h1000);
    neg = 0;
    for (int k = 0; k < 16; k++) begin
      cyc(1, 0, 0, 0);
      if (sample_o == 8'hEF) neg++;
    end
    chk("R4", "square negative count", neg, 8);

    // R5: triangle, peak and trough
    req = "R5";
    wr(1, 0); wr(2, 16'h0040); wr(6, 16'h0800);
    for (int k = 1; k <= 32; k++) begin
      cyc(1, 0, 0, 0);
      if (k == 16) chk("R5", "triangle at half phase", int'(sample_o), 8'h3F);
      if (k == 32) chk("R5", "triangle at zero phase", int'(sample_o), 8'hC0);
    end
    wr(2, 16'h00C0);
    strobes(12, 0);

    // R6 R7: noise sequence and state write
    req = "R6 R7";
    wr(2, 0); wr(3, 16'h0030); wr(7, 16'h0001);
    strobes(40, 0);
    cyc(1, 1, 7, 16'h4000);
    chk("R6", "load wins over shift", int'(sample_o), 8'h30);
    cyc(1, 0, 0, 0);
    chk("R7", "state 0x8001 is negative", int'(sample_o), 8'hD0);
    wr(7, 16'hBEEF);
    strobes(20, 1);

    // R8: full mix with wrap and direct byte
    req = "R8";
    wr(0, 16'h007F); wr(1, 16'h007F); wr(2, 16'h007F); wr(3, 16'h007F);
    wr(4, 16'h1234); wr(5, 16'h0456); wr(6, 16'h0999); wr(8, 16'h0090);
    strobes(40, 1);

    // R1: writes without a strobe leave the output alone
    req = "R1";
    prev = int'(sample_o);
    wr(8, 16'h0011);
    chk("R1", "direct byte before strobe", int'(sample_o), prev);
    wr(0, 16'h0005);
    chk("R1", "volume before strobe", int'(sample_o), prev);
    for (int a = 10; a < 16; a++) wr(a, 16'hFFFF);
    strobes(4, 0);
    cyc(1, 1, 8, 16'h0055);
    strobes(3, 0);

    // R2: phase advance across gaps
    req = "R2";
    wr(4, 16'hF001);
    for (int i = 0; i < 10; i++) begin
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
    end

    // R9: short periods
    req = "R9";
    wr(9, 3);
    strobes(20, 1);
    wr(9, 1);
    strobes(10, 0);
    cyc(1, 1, 9, 2);
    strobes(10, 1);

    finish_run();
  end
endmodule